// File: doc/BRIEF.md
# Buffered SPI master

This block is a register-mapped SPI master for a small processor bus. Software writes a byte into a transmit holding register. The block moves that byte into an 8-bit shift register, drives the serial clock, and shifts the byte out on MOSI. At the same time it shifts the incoming MISO bits into the same register. When the eighth bit completes, the block parks the received byte in a receive holding register. Because both directions are buffered, software can queue the next byte while the current one is still shifting, and it can collect a received byte while the next one is on the wire.

The bus side is a plain register port with no back-pressure. A write is accepted in the cycle that `bus_wr` is high. `bus_rdata` shows the addressed register combinationally, in the same cycle as `bus_rd`. A read is acted on (its clear side effects) at the clock edge that ends that cycle. Register offsets: 0 control, 1 prescaler, 2 status, 3 transmit data (write), 4 receive data (read). A write to the transmit register while it is already full overwrites the waiting byte.

Two interrupt lines summarise the status for an interrupt controller.

Top module: `spim_top`

## Requirements
- R1: After reset:
  - control reads 0x00, the prescaler reads 4, and status reads 0x02;
  - `spi_ss_n` is 1, `spi_sclk` is 0, `spi_mosi` is 1, and both interrupt lines are 0.
- R2: The control register has these bits:
  - bit 6 transmitter enable;
  - bit 5 receiver enable;
  - bit 4 block enable;
  - bit 3 automatic select;
  - bit 2 LSB-first;
  - bit 1 clock polarity.

  Bits 7 and 0 always read 0.
- R3: One serial bit lasts exactly the prescaler value in system clock cycles. A prescaler value of 0 or 1 acts as 2, but reads back as written. When no byte is shifting, `spi_sclk` idles at the polarity bit.
- R4: The edge timing depends on polarity:
  - With polarity 0, the first clock edge of a bit rises and MISO is sampled on the falling edge.
  - With polarity 1, the first edge falls and MISO is sampled on the rising edge.
  - MOSI changes only at the start of a bit.
- R5: With LSB-first at 0, bit 7 of the byte goes out first and the first received bit lands in bit 7. With LSB-first at 1, bit 0 is first in both directions.
- R6: With block enable and automatic select both set, `spi_ss_n` is 0 for the whole of every transfer. Otherwise it stays at 1.
- R7: Status bit 1 (transmit empty) clears in the cycle after a write to the transmit register. It sets again when that byte moves into the shift register.
- R8: Status bit 0 (receive full) sets when a byte lands in the receive register, and clears after the receive register is read. With the receiver enable at 0, received bytes are dropped and bit 0 stays 0.
- R9: Status bit 3 (transfer end) sets when a byte finishes and status bit 2 (overrun) sets on an overrun. Both clear after a status read, unless a new event arrives in that same cycle.
- R10: A byte that finishes while the receive register is full and is not being read is discarded, and the overrun flag sets. The older byte is kept.
- R11: Status bit 4 (busy) is 1 from the cycle after a byte is loaded into the shift register until its eighth bit completes.
- R12: A byte waiting in the transmit register when the current byte finishes starts on the next bit period with no idle gap. `spi_ss_n` stays low across the boundary.
- R13: No byte starts unless both block enable and transmitter enable are set. Clearing block enable aborts a byte in progress.
- R14: The interrupt lines are defined as follows:
  - `irq_xmit` is 1 when transfer end is set, or when the block and the transmitter are enabled and the transmit register is empty.
  - `irq_recv` is 1 when receive full or overrun is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears flags on read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Active-low slave select |
| irq_xmit | output | 1 | Transmit-side interrupt request |
| irq_recv | output | 1 | Receive-side interrupt request |

## Verification
The properties rely on the following assumptions about how the block is driven:
- Control and prescaler are rewritten only while no byte is shifting.
- At most one bus strobe is active per cycle.
- MISO is stable from the first clock edge of a bit to its sampling edge.

The bench keeps within these rules. It reconfigures only after waiting out a full transfer and drives one strobe per bus task. Its slave model changes MISO on the first edge of each bit, half a bit period before the master samples it.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd4;

  // control bit positions (software-visible)
  localparam int CB_TXEN = 6;
  localparam int CB_RXEN = 5;
  localparam int CB_ON   = 4;
  localparam int CB_ASS  = 3;
  localparam int CB_LSB  = 2;
  localparam int CB_POL  = 1;

  // status bit positions (software-visible)
  localparam int SB_BUSY = 4;
  localparam int SB_END  = 3;
  localparam int SB_OVR  = 2;
  localparam int SB_TXE  = 1;
  localparam int SB_RXF  = 0;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic on;
    logic auto_ss;
    logic lsb;
    logic pol;
  } ctrl_t;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
#(
  parameter int MIN_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [BYTE_W-1:0] div_raw,
  output logic              phase_hi,
  output logic              bit_end
);
  localparam logic [BYTE_W-1:0] MIN_V = BYTE_W'(MIN_DIV);

  logic [BYTE_W-1:0] eff;
  logic [BYTE_W-1:0] half;
  logic [BYTE_W-1:0] cnt;

  always_comb begin
    eff  = (div_raw < MIN_V) ? MIN_V : div_raw;
    half = eff >> 1;
  end

  assign phase_hi = run && (cnt >= half);
  assign bit_end  = run && (cnt >= eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart || bit_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              bit_end,
  input  logic              lsb_first,
  input  logic              miso,
  output logic              busy,
  output logic              mosi,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_word
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] nxt;

  // one register serves both directions: out at one end, in at the other
  always_comb begin
    if (lsb_first) nxt = {miso, sh[BYTE_W-1:1]};
    else           nxt = {sh[BYTE_W-2:0], miso};
  end

  assign byte_done = busy && bit_end && (bitcnt == LAST);
  assign rx_word   = nxt;
  assign mosi      = busy ? (lsb_first ? sh[0] : sh[BYTE_W-1]) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      bitcnt <= '0;
      busy   <= 1'b0;
    end else if (abort) begin
      bitcnt <= '0;
      busy   <= 1'b0;
    end else if (load) begin
      sh     <= load_data;
      bitcnt <= '0;
      busy   <= 1'b1;
    end else if (busy && bit_end) begin
      sh <= nxt;
      if (bitcnt == LAST) begin
        busy   <= 1'b0;
        bitcnt <= '0;
      end else begin
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_word,
  output ctrl_t             ctrl,
  output logic [BYTE_W-1:0] div_q,
  output logic              load,
  output logic [BYTE_W-1:0] tx_hold,
  output logic              tx_full,
  output logic [BYTE_W-1:0] rx_hold,
  output logic              rx_full,
  output logic              tend,
  output logic              ovr
);
  logic wr_ctrl, wr_div, wr_tx, rd_stat, rd_rx, capture, lost;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    wr_div  = bus_wr && (bus_addr == A_DIV);
    wr_tx   = bus_wr && (bus_addr == A_TXD);
    rd_stat = bus_rd && (bus_addr == A_STAT);
    rd_rx   = bus_rd && (bus_addr == A_RXD);
    // reload in the same edge the previous byte ends: no idle bit
    load    = ctrl.on && ctrl.tx_en && tx_full && (!busy || byte_done);
    capture = byte_done && ctrl.rx_en;
    lost    = capture && rx_full && !rd_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      div_q <= BYTE_W'(DIV_RESET);
    end else begin
      if (wr_ctrl) begin
        ctrl.tx_en   <= bus_wdata[CB_TXEN];
        ctrl.rx_en   <= bus_wdata[CB_RXEN];
        ctrl.on      <= bus_wdata[CB_ON];
        ctrl.auto_ss <= bus_wdata[CB_ASS];
        ctrl.lsb     <= bus_wdata[CB_LSB];
        ctrl.pol     <= bus_wdata[CB_POL];
      end
      if (wr_div) div_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold <= '0;
      tx_full <= 1'b0;
    end else if (wr_tx) begin
      tx_hold <= bus_wdata;
      tx_full <= 1'b1;
    end else if (load) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold <= '0;
      rx_full <= 1'b0;
    end else if (capture && !lost) begin
      rx_hold <= rx_word;
      rx_full <= 1'b1;
    end else if (rd_rx) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (byte_done)    tend <= 1'b1;
      else if (rd_stat) tend <= 1'b0;
      if (lost)         ovr  <= 1'b1;
      else if (rd_stat) ovr  <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CB_TXEN] = ctrl.tx_en;
        bus_rdata[CB_RXEN] = ctrl.rx_en;
        bus_rdata[CB_ON]   = ctrl.on;
        bus_rdata[CB_ASS]  = ctrl.auto_ss;
        bus_rdata[CB_LSB]  = ctrl.lsb;
        bus_rdata[CB_POL]  = ctrl.pol;
      end
      A_DIV: bus_rdata = div_q;
      A_STAT: begin
        bus_rdata[SB_BUSY] = busy;
        bus_rdata[SB_END]  = tend;
        bus_rdata[SB_OVR]  = ovr;
        bus_rdata[SB_TXE]  = !tx_full;
        bus_rdata[SB_RXF]  = rx_full;
      end
      A_RXD:   bus_rdata = rx_hold;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DIV_RESET = 4,
  parameter int MIN_DIV   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_ss_n,
  output logic       irq_xmit,
  output logic       irq_recv
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] div_q, tx_hold, rx_hold, rx_word;
  logic              load, tx_full, rx_full, tend, ovr;
  logic              busy, byte_done, phase_hi, bit_end;

  spim_regs #(.DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .byte_done(byte_done), .rx_word(rx_word),
    .ctrl(ctrl), .div_q(div_q), .load(load),
    .tx_hold(tx_hold), .tx_full(tx_full),
    .rx_hold(rx_hold), .rx_full(rx_full),
    .tend(tend), .ovr(ovr)
  );

  spim_clkdiv #(.MIN_DIV(MIN_DIV)) u_div (
    .clk(clk), .rst_n(rst_n),
    .run(busy), .restart(load), .div_raw(div_q),
    .phase_hi(phase_hi), .bit_end(bit_end)
  );

  spim_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .abort(!ctrl.on), .load(load), .load_data(tx_hold),
    .bit_end(bit_end), .lsb_first(ctrl.lsb), .miso(spi_miso),
    .busy(busy), .mosi(spi_mosi), .byte_done(byte_done), .rx_word(rx_word)
  );

  assign spi_sclk = ctrl.pol ^ phase_hi;
  assign spi_ss_n = !(ctrl.on && ctrl.auto_ss && busy);
  assign irq_xmit = tend || (ctrl.on && ctrl.tx_en && !tx_full);
  assign irq_recv = rx_full || ovr;
endmodule

// File: rtl/spim_top_chk.sv
module spim_top_chk
  import spim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              spi_sclk,
  input logic              spi_ss_n,
  input ctrl_t             ctrl,
  input logic              busy,
  input logic              load,
  input logic              byte_done,
  input logic              tx_full,
  input logic              rx_full,
  input logic              tend,
  input logic              ovr,
  input logic [BYTE_W-1:0] rx_hold
);
  logic rd_rx, rd_stat, wr_tx;
  assign rd_rx   = bus_rd && (bus_addr == A_RXD);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign wr_tx   = bus_wr && (bus_addr == A_TXD);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == ctrl.pol));
  p_ss_manual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.on && ctrl.auto_ss) |-> spi_ss_n);
  p_txe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> tx_full);
  p_rxf_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !byte_done) |=> !rx_full);
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !byte_done) |=> (!tend && !ovr));
  p_ovr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_rx) |=> $stable(rx_hold));
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  p_ss_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(ctrl)) |-> $stable(spi_ss_n));
  p_no_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.on && ctrl.tx_en) |-> !load);
endmodule

bind spim_top spim_top_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n),
  .ctrl(ctrl), .busy(busy), .load(load), .byte_done(byte_done),
  .tx_full(tx_full), .rx_full(rx_full), .tend(tend), .ovr(ovr),
  .rx_hold(rx_hold)
);

// File: tb/spim_top_test.sv
`timescale 1ns/1ps
module spim_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sclk, spi_mosi, spi_ss_n, irq_xmit, irq_recv;
  logic       spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  spim_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_ss_n(spi_ss_n), .irq_xmit(irq_xmit), .irq_recv(irq_recv)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // bench-side slave model state
  logic       cur_pol = 0, cur_lsb = 0, mon_clear = 0;
  logic [7:0] slave_b [0:1];
  logic [7:0] cap_b   [0:1];
  logic [7:0] acc = '0;
  int ncap = 0, nbit = 0, nlead = 0, ss_rises = 0;
  int per_min = 0, per_max = 0, last_lead = 0, cyc = 0;
  bit ss_low_seen = 0;
  logic prev_sclk = 0, prev_ss = 1;

  always @(negedge clk) begin
    cyc++;
    if (mon_clear) begin
      ncap = 0; nbit = 0; nlead = 0; ss_rises = 0; ss_low_seen = 0;
      per_min = 1000; per_max = 0; acc = '0;
    end else begin
      if (!spi_ss_n) ss_low_seen = 1;
      if (spi_ss_n && !prev_ss) ss_rises++;
      if (spi_sclk != prev_sclk && spi_sclk != cur_pol) begin
        if (nlead > 0) begin
          if (cyc - last_lead < per_min) per_min = cyc - last_lead;
          if (cyc - last_lead > per_max) per_max = cyc - last_lead;
        end
        last_lead = cyc;
        nlead++;
        acc = {acc[6:0], spi_mosi};
        spi_miso = cur_lsb ? slave_b[ncap % 2][nbit] : slave_b[ncap % 2][7 - nbit];
        nbit++;
        if (nbit == 8) begin
          cap_b[ncap % 2] = acc;
          ncap++;
          nbit = 0;
        end
      end
    end
    prev_sclk = spi_sclk;
    prev_ss = spi_ss_n;
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7 - i];
  endfunction

  function automatic int eff_div(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic logic [7:0] ctrl_val(input bit te, re, on, ass, lsb, pol);
    return {1'b0, te, re, on, ass, lsb, pol, 1'b0};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic mclear();
    @(posedge clk); mon_clear = 1;
    @(posedge clk); mon_clear = 0;
  endtask

  task automatic one_xfer(input bit pol, lsb, ass, input int div,
                          input logic [7:0] tx, input logic [7:0] sb);
    logic [7:0] v;
    cur_pol = pol; cur_lsb = lsb; slave_b[0] = sb;
    bw(3'd0, ctrl_val(1, 1, 1, ass, lsb, pol));
    bw(3'd1, div[7:0]);
    mclear();
    #1 check("R3 idle clock level", spi_sclk, pol);
    bw(3'd3, tx);
    repeat (8 * eff_div(div) + 6) @(negedge clk);
    check("R5 MOSI byte order", cap_b[0], lsb ? rev8(tx) : tx);
    check("R3 bit period min", per_min, eff_div(div));
    check("R3 bit period max", per_max, eff_div(div));
    check("R6 select during transfer", ss_low_seen, ass);
    br(3'd2, v);
    check("R9 status after byte", v, 8'h0B);
    br(3'd2, v);
    check("R9 transfer end cleared by read", v, 8'h03);
    br(3'd4, v);
    check("R4 received byte", v, sb);
    br(3'd2, v);
    check("R8 receive full cleared", v, 8'h02);
  endtask

  logic [7:0] rv;
  int unsigned seed_dummy;

  initial begin
    slave_b[0] = 8'h00; slave_b[1] = 8'h00;
    seed_dummy = $urandom(32'd715);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    br(3'd0, rv); check("R1 control reset", rv, 8'h00);
    br(3'd1, rv); check("R1 prescaler reset", rv, 8'h04);
    br(3'd2, rv); check("R1 status reset", rv, 8'h02);
    check("R1 select idle", spi_ss_n, 1);
    check("R1 clock idle", spi_sclk, 0);
    check("R1 mosi idle", spi_mosi, 1);
    check("R1 irq lines", {irq_xmit, irq_recv}, 0);
    // R2 reserved bits
    bw(3'd0, 8'hFF);
    br(3'd0, rv); check("R2 reserved bits read zero", rv, 8'h7E);
    bw(3'd0, 8'h00);
    // R13 no start without transmitter enable; R7 flag clears on write
    bw(3'd0, ctrl_val(0, 1, 1, 1, 0, 0));
    mclear();
    bw(3'd3, 8'hA5);
    br(3'd2, rv); check("R7 transmit empty clears on write", rv, 8'h00);
    repeat (40) @(negedge clk);
    check("R13 no clocks with transmitter off", nlead, 0);
    bw(3'd0, ctrl_val(1, 1, 0, 1, 0, 0));
    repeat (40) @(negedge clk);
    check("R13 no clocks with block off", nlead, 0);
    br(3'd2, rv); check("R13 byte still waiting", rv, 8'h00);
    check("R14 irq_xmit low while full", irq_xmit, 0);
    bw(3'd0, ctrl_val(1, 1, 1, 1, 0, 0));
    repeat (2) @(negedge clk);
    br(3'd2, rv); check("R11 busy after load, R7 empty again", rv, 8'h12);
    repeat (40) @(negedge clk);
    check("R14 irq_recv after byte", irq_recv, 1);
    br(3'd2, rv); br(3'd4, rv);
    check("R14 irq lines idle", {irq_xmit, irq_recv}, 2'b10);
    // directed modes
    one_xfer(0, 0, 1, 4, 8'hC3, 8'h5A);
    one_xfer(1, 1, 1, 5, 8'h81, 8'h3C);
    one_xfer(1, 0, 0, 3, 8'h6E, 8'h99);
    one_xfer(0, 1, 1, 0, 8'h17, 8'hE4);
    br(3'd1, rv); check("R3 prescaler reads as written", rv, 8'h00);
    // random modes
    for (int i = 0; i < 12; i++) begin
      one_xfer($urandom % 2, $urandom % 2, $urandom % 2, 2 + $urandom % 8,
               8'($urandom), 8'($urandom));
    end
    // R12 back-to-back and R10 overrun
    cur_pol = 0; cur_lsb = 0; slave_b[0] = 8'h11; slave_b[1] = 8'h22;
    bw(3'd0, ctrl_val(1, 1, 1, 1, 0, 0));
    bw(3'd1, 8'd4);
    mclear();
    bw(3'd3, 8'hF0);
    repeat (3) @(negedge clk);
    bw(3'd3, 8'h0F);
    repeat (16 * 4 + 8) @(negedge clk);
    check("R12 two bytes sent", ncap, 2);
    check("R12 second byte", cap_b[1], 8'h0F);
    check("R12 no gap between bytes", per_max, 4);
    check("R12 select held low", ss_rises, 1);
    br(3'd2, rv); check("R10 overrun status", rv, 8'h0F);
    br(3'd4, rv); check("R10 older byte kept", rv, 8'h11);
    br(3'd2, rv); check("R9 overrun cleared by read", rv, 8'h02);
    // R8 receiver disabled
    slave_b[0] = 8'h77;
    bw(3'd0, ctrl_val(1, 0, 1, 1, 0, 0));
    bw(3'd3, 8'h42);
    repeat (8 * 4 + 6) @(negedge clk);
    br(3'd2, rv); check("R8 no capture with receiver off", rv, 8'h0A);
    br(3'd4, rv); check("R8 receive register untouched", rv, 8'h11);
    // R13 abort
    bw(3'd0, ctrl_val(1, 1, 1, 1, 0, 0));
    bw(3'd3, 8'h99);
    repeat (6) @(negedge clk);
    bw(3'd0, ctrl_val(1, 1, 0, 1, 0, 0));
    #1 check("R13 abort releases select", spi_ss_n, 1);
    br(3'd2, rv); check("R13 abort clears busy", rv, 8'h02);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule